// File: doc/BRIEF.md
# Comma-Framed Word Aligner with Alternating Word Clocks

The block sits behind a clock and data recovery stage and runs on the recovered bit-rate clock. It shifts in one serial bit per cycle, cuts the stream into 10-bit words and presents each word on a parallel output. Each presented word is marked by the rising edge of one of two word clocks. These clocks take turns word by word, so each one runs at half the word rate.

While the align enable input is high, the block watches the stream for the 10-bit comma that is sent as 0,0,1,1,1,1,1,0,1,0 in time order. Every comma produces a one-cycle pulse. If the comma does not already sit on the current word boundary, or would land on the wrong word clock, the block re-frames its words so that the comma starts a new word. That comma word is then presented on the even-word clock. While this re-framing happens, the word clocks hold their levels longer than usual and never switch early. With align enable low, the framing free-runs from reset and commas are ignored.

Top module: `comma_aligner`

## Requirements
- R1: When align enable is high, the comma is recognised when its last bit is sampled. The bits are 0,0,1,1,1,1,1,0,1,0 in arrival order, which is 10'b0101111100 with bit 0 the earliest. `comma_pulse` is high in the cycle after the sampling edge.
- R2: `comma_pulse` is high for exactly one cycle per recognised comma, and it never pulses without a comma.
- R3: While `align_en` is low, `comma_pulse` stays low and word framing stays unchanged, even when a comma passes through the stream.
- R4: Bit 0 of `word_out` is the earliest received bit of that word.
- R5: Each presented word raises exactly one word clock. Successive words alternate between `wclk_even` and `wclk_odd`, and the two clocks are never high together.
- R6: After a re-framing comma, the comma word appears on `word_out` together with a rising edge of `wclk_even`, exactly 20 bit cycles after the edge that sampled its last bit. No word is presented in between.
- R7: When a comma ends off the current word boundary, the following words are framed starting at the bit after the comma.
- R8: A comma that ends on the current boundary keeps the framing. If its word would go out on `wclk_even`, the word stream continues without a gap. If it would go out on `wclk_odd`, the block re-frames as in R6.
- R9: Each high or low level of either word clock lasts at least 10 bit cycles.
- R10: `word_out` changes only in cycles where one of the word clocks rises, and it holds its value between those cycles.
- R11: A synchronous reset clears `word_out`, drives both word clocks low and holds `comma_pulse` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Recovered bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| align_en | input | 1 | Enables comma search and re-framing |
| ser_in | input | 1 | Serial data bit, sampled on each rising clock edge |
| word_out | output | 10 | Presented word, bit 0 earliest received |
| wclk_even | output | 1 | Word clock that rises for even words; the comma word is word 0 |
| wclk_odd | output | 1 | Word clock that rises for odd words |
| comma_pulse | output | 1 | One-cycle pulse per recognised comma |

## Verification
The assertions check four things on every cycle: the word clocks are mutually exclusive, each clock level lasts at least 10 cycles, the word register moves only on a clock rise, and the pulse is one cycle wide and silent while alignment is off. Only the scenarios can show the rest. They show that the comma word arrives on the even clock exactly 20 cycles after detection, that framing moves to the comma's position, that an aligned comma on an even slot leaves the stream untouched, and that a comma passing with alignment off changes nothing. The scenarios also show that bit 0 is the first bit received.

// File: rtl/comma_aligner.sv
module comma_aligner #(
  parameter int WLEN = 10,
  parameter logic [WLEN-1:0] COMMA = 10'b0101111100
) (
  input  logic            bit_clk,
  input  logic            rst,
  input  logic            align_en,
  input  logic            ser_in,
  output logic [WLEN-1:0] word_out,
  output logic            wclk_even,
  output logic            wclk_odd,
  output logic            comma_pulse
);
  localparam int CW = $clog2(WLEN);
  localparam int RW = $clog2(WLEN + 1);

  typedef enum logic [1:0] {RUN, STRETCH, GAP} stage_t;

  logic [WLEN-1:0] shreg, slot0, slot1;
  logic            par0, par1;
  logic [CW-1:0]   bcnt;
  stage_t          stage;

  wire [WLEN-1:0] shnext  = {ser_in, shreg[WLEN-1:1]};
  wire            at_bnd  = (bcnt == CW'(WLEN - 1));
  wire            hit     = align_en && (shnext == COMMA);
  wire            keep    = at_bnd && par0 && (stage == RUN);
  wire            realign = hit && !keep;

  always_ff @(posedge bit_clk) begin
    if (rst) begin
      shreg       <= '0;
      slot0       <= '0;
      slot1       <= '0;
      par0        <= 1'b1;
      par1        <= 1'b0;
      bcnt        <= '0;
      stage       <= RUN;
      word_out    <= '0;
      wclk_even   <= 1'b0;
      wclk_odd    <= 1'b0;
      comma_pulse <= 1'b0;
    end else begin
      shreg       <= shnext;
      comma_pulse <= hit;
      if (realign) begin
        bcnt  <= '0;
        slot0 <= shnext;
        par0  <= 1'b0;
        stage <= STRETCH;
      end else if (at_bnd) begin
        bcnt  <= '0;
        slot0 <= shnext;
        par0  <= ~par0;
        slot1 <= slot0;
        par1  <= par0;
        case (stage)
          STRETCH: begin
            wclk_even <= 1'b0;
            wclk_odd  <= 1'b0;
            stage     <= GAP;
          end
          default: begin
            word_out  <= slot1;
            wclk_even <= ~par1;
            wclk_odd  <= par1;
            stage     <= RUN;
          end
        endcase
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  logic          seen_even, seen_odd;
  logic [RW-1:0] run_even, run_odd;

  always_ff @(posedge bit_clk) begin
    if (rst) begin
      seen_even <= 1'b0;
      seen_odd  <= 1'b0;
      run_even  <= RW'(WLEN);
      run_odd   <= RW'(WLEN);
    end else begin
      seen_even <= wclk_even;
      seen_odd  <= wclk_odd;
      if (wclk_even != seen_even) run_even <= RW'(1);
      else if (run_even != RW'(WLEN)) run_even <= run_even + 1'b1;
      if (wclk_odd != seen_odd) run_odd <= RW'(1);
      else if (run_odd != RW'(WLEN)) run_odd <= run_odd + 1'b1;
    end
  end

  a_r5_clocks_exclusive: assert property (@(posedge bit_clk) disable iff (rst)
    !(wclk_even && wclk_odd));

  a_r9_even_phase_min: assert property (@(posedge bit_clk) disable iff (rst)
    (wclk_even != seen_even) |-> (run_even >= RW'(WLEN)));

  a_r9_odd_phase_min: assert property (@(posedge bit_clk) disable iff (rst)
    (wclk_odd != seen_odd) |-> (run_odd >= RW'(WLEN)));

  a_r10_word_hold: assert property (@(posedge bit_clk) disable iff (rst)
    (word_out != $past(word_out)) |-> ($rose(wclk_even) || $rose(wclk_odd)));

  a_r3_quiet_when_off: assert property (@(posedge bit_clk) disable iff (rst)
    !$past(align_en) |-> !comma_pulse);

  a_r2_single_pulse: assert property (@(posedge bit_clk) disable iff (rst)
    comma_pulse |=> !comma_pulse);
endmodule

// File: tb/comma_aligner_tb_top.sv
`timescale 1ns/100ps
module comma_aligner_tb_top;
  localparam int W = 10;
  localparam logic [W-1:0] COMMA = 10'b0101111100;

  logic bit_clk = 1'b0;
  logic rst = 1'b1;
  logic align_en = 1'b0;
  logic ser_in = 1'b0;
  logic [W-1:0] word_out;
  logic wclk_even, wclk_odd, comma_pulse;

  comma_aligner #(.WLEN(W), .COMMA(COMMA)) dut_i (
    .bit_clk(bit_clk), .rst(rst), .align_en(align_en), .ser_in(ser_in),
    .word_out(word_out), .wclk_even(wclk_even), .wclk_odd(wclk_odd),
    .comma_pulse(comma_pulse)
  );

  always #2.5 bit_clk = ~bit_clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge bit_clk) cyc++;

  logic [W:0] expq[$];
  int syncq[$];
  logic [W-1:0] mb = '0;
  int mcnt = 0;
  bit mpar = 1'b0;
  int mstate = 0;
  int hunt_cyc = 0;
  string wtag = "R4 R5";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_bit(input logic b);
    mb = {b, mb[W-1:1]};
    mcnt++;
    if (mcnt == W) begin
      expq.push_back({mpar, mb});
      mpar = ~mpar;
      mcnt = 0;
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge bit_clk);
    ser_in = b;
    model_bit(b);
  endtask

  task automatic send_word(input logic [W-1:0] w);
    for (int i = 0; i < W; i++) send_bit(w[i]);
  endtask

  task automatic send_comma(input string tag);
    for (int i = 0; i < W - 1; i++) send_bit(COMMA[i]);
    @(negedge bit_clk);
    ser_in = COMMA[W-1];
    if (align_en) begin
      syncq.push_back(cyc + 1);
      if (mcnt == W - 1 && mpar == 1'b0 && mstate == 2) begin
        model_bit(COMMA[W-1]);
      end else begin
        expq.delete();
        mcnt = 0;
        mpar = 1'b1;
        hunt_cyc = cyc + 1 + 2 * W;
        mstate = 1;
      end
    end else begin
      model_bit(COMMA[W-1]);
    end
    wtag = tag;
  endtask

  task automatic send_data();
    send_word(10'h155);
    send_word(10'h2AA);
    send_word(10'h0F0);
    send_word(10'h0CC);
    send_word(10'h333);
    send_word(10'h1E6);
  endtask

  // monitor: scoreboard pop, clock phase, word hold and pulse checks
  initial begin
    logic la = 1'b0, lb = 1'b0, ls = 1'b0;
    logic [W-1:0] lw = '0;
    int runa = 100, runb = 100;
    forever begin
      @(posedge bit_clk);
      #1;
      if (!rst) begin
        automatic bit rise_a = wclk_even && !la;
        automatic bit rise_b = wclk_odd && !lb;
        check(!(wclk_even && wclk_odd), "R5 exclusive", {wclk_even, wclk_odd}, 0);
        if (wclk_even != la) begin check(runa >= W, "R9 even phase", runa, W); runa = 1; end
        else runa++;
        if (wclk_odd != lb) begin check(runb >= W, "R9 odd phase", runb, W); runb = 1; end
        else runb++;
        if (word_out != lw) check(rise_a || rise_b, "R10 word hold", word_out, lw);
        if (comma_pulse) begin
          check(!ls, "R2 pulse width", ls, 0);
          if (syncq.size() == 0) check(0, "R3 R2 unexpected pulse", cyc, -1);
          else begin
            automatic int e = syncq.pop_front();
            check(cyc == e, "R1 pulse cycle", cyc, e);
          end
        end
        if (rise_a || rise_b) begin
          if (mstate == 1) begin
            check(rise_a && word_out == COMMA, "R6 comma word on even clock", {rise_b, word_out}, {1'b0, COMMA});
            check(cyc == hunt_cyc, "R6 comma latency", cyc, hunt_cyc);
            mstate = 2;
          end else if (mstate == 2) begin
            if (expq.size() == 0) check(0, "R5 no word expected", word_out, -1);
            else begin
              automatic logic [W:0] e = expq.pop_front();
              check({rise_b, word_out} == e, wtag, {rise_b, word_out}, e);
            end
          end
        end
        la = wclk_even; lb = wclk_odd; lw = word_out; ls = comma_pulse;
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge bit_clk);
    check(word_out == '0, "R11 reset word", word_out, 0);
    check(!wclk_even && !wclk_odd, "R11 reset clocks", {wclk_even, wclk_odd}, 0);
    check(!comma_pulse, "R11 reset pulse", comma_pulse, 0);
    @(negedge bit_clk);
    rst = 1'b0;
    align_en = 1'b1;
    model_bit(1'b0);
    send_bit(1'b0);
    send_bit(1'b0);
    // misaligned comma after reset
    send_comma("R4 R5 R7 after first comma");
    send_data();
    // pad so the next comma ends on a boundary with even parity
    while (!(mcnt == 0 && mpar == 1'b0)) send_bit(1'b0);
    send_comma("R8 aligned even comma");
    send_data();
    // aligned comma on an odd slot
    while (!(mcnt == 0 && mpar == 1'b1)) send_bit(1'b0);
    send_comma("R8 R7 aligned odd comma");
    send_data();
    // comma seven bits off the boundary
    while (mcnt != 0) send_bit(1'b0);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    send_comma("R7 offset comma");
    send_data();
    // alignment off: comma passes unframed
    repeat (25) send_bit(1'b0);
    align_en = 1'b0;
    wtag = "R3 framing kept";
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    send_comma("R3 framing kept");
    send_data();
    repeat (25) send_bit(1'b0);
    align_en = 1'b1;
    wtag = "R4 R5 resumed";
    send_data();
    repeat (3 * W) send_bit(1'b0);
    check(syncq.size() == 0, "R2 pulses per comma", syncq.size(), 0);
    check(expq.size() <= 3, "R5 words kept flowing", expq.size(), 3);
    check(mstate == 2, "R6 alignment reached", mstate, 2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule